// File: doc/BRIEF.md
# Row-Parallel Correlation Multiply-Accumulate Engine

This block computes raw, non-normalised cross-correlation scores between a short template image and a taller search image of the same width. The default width is 32 pixels. A row pair is presented each cycle, one template row and the search row that lines up with it at the current vertical placement. All column products are formed in parallel, and each column keeps its own running sum over the template rows. When the caller marks the last row of a placement, the column sums are reduced by a registered adder tree into one score.

An upstream sequencer walks the placements one vertical offset at a time and streams the matching row pairs. It ends each placement with the last-row flag and may insert idle cycles anywhere. A new placement can start on the cycle right after a last row. The engine produces one score per placement, marked by a single-cycle valid pulse that lines up with the data. Normalisation, memory addressing and peak search belong to other blocks.

Top module: `row_corr_engine`

## Requirements
- R1: After synchronous active-low reset, `res_valid` is low and stays low until a row flagged as last has been accepted.
- R2: Each score equals the sum, over every accepted row of the placement and over all 32 columns, of template pixel times search pixel. Pixels are unsigned 8-bit values, and column c occupies bits [8c+7:8c] of each pixel bus.
- R3: `res_valid` is high for exactly one cycle per placement. It rises on the 9th rising edge after the edge that accepted the placement's last row (operand register, 3 multiply stages, accumulate, 5 adder-tree stages), and scores leave in placement order.
- R4: A cycle with `row_valid` low adds nothing to any sum, whatever the pixel buses carry.
- R5: Column sums restart at each new placement, so a score does not depend on earlier placements.
- R6: A placement of a single row (last flag on its first row) yields the dot product of that row pair.
- R7: Placements of up to 512 rows never overflow. 512 rows of all-255 pixels give exactly 1065369600.
- R8: A placement may begin on the cycle right after the previous last row, and both scores are correct.
- R9: `row_last` has no effect on a cycle where `row_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| row_valid | input | 1 | Row pair on the pixel buses is accepted this cycle |
| row_last | input | 1 | Accepted row is the final row of its placement |
| tmpl_row | input | 256 | Template row, 32 packed 8-bit pixels |
| srch_row | input | 256 | Aligned search row, 32 packed 8-bit pixels |
| res_valid | output | 1 | Score on `res_score` is valid this cycle |
| res_score | output | 30 | Correlation score for one placement |

## Verification
The bench aims at the ends of the height range: one-row placements would expose an accumulator that never reloads, and a 512-row all-255 placement would show a truncated accumulator or tree. It runs placements back to back and then interleaves idle cycles that carry junk pixels and a raised last flag. A design that leaked the previous sum, counted invalid rows or ended a placement early would produce wrong or extra scores there. Every score is also checked against the cycle it should appear on, so a valid strobe that is one stage short or long fails even when the value is right.

// File: rtl/row_corr_pkg.sv
// Shared defaults and width helpers for the row correlation engine.
package row_corr_pkg;

    localparam int DEF_LANES    = 32;
    localparam int DEF_PIX_W    = 8;
    localparam int DEF_MAX_ROWS = 512;
    localparam int DEF_MUL_LAT  = 3;

    // Width of one column accumulator that cannot overflow over max_rows rows.
    function automatic int acc_width(input int pix_w, input int max_rows);
        return 2 * pix_w + $clog2(max_rows);
    endfunction

    // Width of the reduced score over all lanes.
    function automatic int sum_width(input int pix_w, input int max_rows, input int lanes);
        return acc_width(pix_w, max_rows) + $clog2(lanes);
    endfunction

endpackage

// File: rtl/row_corr_ctrl.sv
// Control pipeline: carries row valid and last flags alongside the multiply
// pipeline and produces the accumulate enable, the clear select and the
// placement-done strobe. Assumes MUL_LAT >= 1.
module row_corr_ctrl #(
    parameter int MUL_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    output logic acc_en,
    output logic acc_clear,
    output logic acc_done
);
    logic [MUL_LAT:0] vld_q;
    logic [MUL_LAT:0] lst_q;
    logic             fresh_q;
    logic             done_q;

    // Delay valid and qualified last to line up with the final product stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            lst_q <= '0;
        end else begin
            vld_q <= {vld_q[MUL_LAT-1:0], in_valid};
            lst_q <= {lst_q[MUL_LAT-1:0], in_valid & in_last};
        end
    end

    // Track whether the next accumulated row opens a placement.
    always_ff @(posedge clk) begin
        if (!rst_n)             fresh_q <= 1'b1;
        else if (vld_q[MUL_LAT]) fresh_q <= lst_q[MUL_LAT];
    end

    // Flag the cycle in which the column sums hold a finished placement.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= vld_q[MUL_LAT] & lst_q[MUL_LAT];
    end

    assign acc_en    = vld_q[MUL_LAT];
    assign acc_clear = fresh_q;
    assign acc_done  = done_q;
endmodule

// File: rtl/row_corr_lane.sv
// One column: enabled operand register, MUL_LAT-stage product pipeline and a
// running accumulator that reloads on clear. Datapath registers carry no reset;
// the control pipeline decides when their contents are used.
module row_corr_lane #(
    parameter int PIX_W   = 8,
    parameter int MUL_LAT = 3,
    parameter int ACC_W   = 25
) (
    input  logic             clk,
    input  logic             op_en,
    input  logic [PIX_W-1:0] pix_a,
    input  logic [PIX_W-1:0] pix_b,
    input  logic             acc_en,
    input  logic             acc_clear,
    output logic [ACC_W-1:0] acc_q
);
    localparam int PROD_W = 2 * PIX_W;

    logic [PIX_W-1:0]  a_q, b_q;
    logic [PROD_W-1:0] prod_q [MUL_LAT];

    // Capture the operands only for accepted rows.
    always_ff @(posedge clk) begin
        if (op_en) begin
            a_q <= pix_a;
            b_q <= pix_b;
        end
    end

    // Multiply and shift the product through the remaining stages.
    always_ff @(posedge clk) begin
        prod_q[0] <= PROD_W'(a_q) * PROD_W'(b_q);
        for (int s = 1; s < MUL_LAT; s++) prod_q[s] <= prod_q[s-1];
    end

    // Reload or add the product for each valid row.
    always_ff @(posedge clk) begin
        if (acc_en) begin
            if (acc_clear) acc_q <= ACC_W'(prod_q[MUL_LAT-1]);
            else           acc_q <= acc_q + ACC_W'(prod_q[MUL_LAT-1]);
        end
    end
endmodule

// File: rtl/row_corr_tree.sv
// Registered binary adder tree reducing LANES column sums into one score,
// one register level per halving. Assumes LANES is a power of two.
module row_corr_tree #(
    parameter int LANES = 32,
    parameter int ACC_W = 25,
    parameter int SUM_W = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*ACC_W-1:0] leaves,
    output logic                   out_valid,
    output logic [SUM_W-1:0]       out_sum
);
    localparam int LEVELS = $clog2(LANES);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N = LANES >> l;
        logic [N*SUM_W-1:0] node;
        logic               vld;

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < N; i++) begin : g_ext
                assign node[i*SUM_W +: SUM_W] = SUM_W'(leaves[i*ACC_W +: ACC_W]);
            end
            assign vld = in_valid;
        end else begin : g_add
            // Add adjacent pairs of the level below when it holds a result.
            always_ff @(posedge clk) begin
                if (g_lvl[l-1].vld) begin
                    for (int i = 0; i < N; i++) begin
                        node[i*SUM_W +: SUM_W] <= g_lvl[l-1].node[(2*i)*SUM_W +: SUM_W]
                                                + g_lvl[l-1].node[(2*i+1)*SUM_W +: SUM_W];
                    end
                end
            end

            // Carry the valid flag down one level.
            always_ff @(posedge clk) begin
                if (!rst_n) vld <= 1'b0;
                else        vld <= g_lvl[l-1].vld;
            end
        end
    end

    assign out_valid = g_lvl[LEVELS].vld;
    assign out_sum   = g_lvl[LEVELS].node;
endmodule

// File: rtl/row_corr_engine.sv
// Top: LANES parallel multiply-accumulate columns, shared control pipeline and
// a registered reduction tree. One score per placement, valid aligned to data.
// Assumes placements no taller than MAX_ROWS and LANES a power of two.
module row_corr_engine
    import row_corr_pkg::*;
#(
    parameter int LANES    = DEF_LANES,
    parameter int PIX_W    = DEF_PIX_W,
    parameter int MAX_ROWS = DEF_MAX_ROWS,
    parameter int MUL_LAT  = DEF_MUL_LAT,
    localparam int ACC_W   = acc_width(PIX_W, MAX_ROWS),
    localparam int SUM_W   = sum_width(PIX_W, MAX_ROWS, LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   row_valid,
    input  logic                   row_last,
    input  logic [LANES*PIX_W-1:0] tmpl_row,
    input  logic [LANES*PIX_W-1:0] srch_row,
    output logic                   res_valid,
    output logic [SUM_W-1:0]       res_score
);
    logic                   acc_en, acc_clear, acc_done;
    logic [LANES*ACC_W-1:0] col_sums;

    row_corr_ctrl #(.MUL_LAT(MUL_LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (row_valid),
        .in_last   (row_last),
        .acc_en    (acc_en),
        .acc_clear (acc_clear),
        .acc_done  (acc_done)
    );

    for (genvar c = 0; c < LANES; c++) begin : g_col
        row_corr_lane #(.PIX_W(PIX_W), .MUL_LAT(MUL_LAT), .ACC_W(ACC_W)) u_lane (
            .clk       (clk),
            .op_en     (row_valid),
            .pix_a     (tmpl_row[c*PIX_W +: PIX_W]),
            .pix_b     (srch_row[c*PIX_W +: PIX_W]),
            .acc_en    (acc_en),
            .acc_clear (acc_clear),
            .acc_q     (col_sums[c*ACC_W +: ACC_W])
        );
    end

    row_corr_tree #(.LANES(LANES), .ACC_W(ACC_W), .SUM_W(SUM_W)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_done),
        .leaves    (col_sums),
        .out_valid (res_valid),
        .out_sum   (res_score)
    );
endmodule

// File: rtl/row_corr_engine_chk.sv
// Checker bound to the engine: keeps an independent model of when a score
// must leave and bounds its value.
module row_corr_engine_chk #(
    parameter int LANES    = 32,
    parameter int PIX_W    = 8,
    parameter int MAX_ROWS = 512,
    parameter int MUL_LAT  = 3,
    parameter int SUM_W    = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             row_valid,
    input logic             row_last,
    input logic             res_valid,
    input logic [SUM_W-1:0] res_score
);
    localparam int LAT = 1 + MUL_LAT + $clog2(LANES);
    localparam longint PIX_MAX = (64'd1 << PIX_W) - 1;
    localparam longint SCORE_MAX = longint'(LANES) * longint'(MAX_ROWS) * PIX_MAX * PIX_MAX;

    logic [LAT:0] due_q;

    // Model of the placement-end flags travelling towards the output.
    always_ff @(posedge clk) begin
        if (!rst_n) due_q <= '0;
        else        due_q <= {due_q[LAT-1:0], row_valid & row_last};
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid);

    assert_valid_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(res_valid));

    assert_valid_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == due_q[LAT]);

    assert_score_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_score));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (64'(res_score) <= SCORE_MAX));
endmodule

bind row_corr_engine row_corr_engine_chk #(
    .LANES(LANES), .PIX_W(PIX_W), .MAX_ROWS(MAX_ROWS), .MUL_LAT(MUL_LAT), .SUM_W(SUM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_valid (row_valid),
    .row_last  (row_last),
    .res_valid (res_valid),
    .res_score (res_score)
);

// File: tb/row_corr_engine_tb.sv
// Scoreboard bench: the driver queues expected scores and their due cycle,
// the monitor compares each result as it leaves the engine.
module row_corr_engine_tb;
    localparam int LANES = 32;
    localparam int PIX_W = 8;
    localparam int LAT   = 9;

    typedef struct {
        longint val;
        int     cyc;
        string  tag;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   row_valid = 1'b0;
    logic                   row_last = 1'b0;
    logic [LANES*PIX_W-1:0] tmpl_row = '0;
    logic [LANES*PIX_W-1:0] srch_row = '0;
    logic                   res_valid;
    logic [29:0]            res_score;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t sbq[$];

    row_corr_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .row_last  (row_last),
        .tmpl_row  (tmpl_row),
        .srch_row  (srch_row),
        .res_valid (res_valid),
        .res_score (res_score)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every result must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R3 unexpected result", longint'(res_score), -1);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(longint'(res_score) == e.val, {e.tag, " R2 score"}, longint'(res_score), e.val);
                check(cyc == e.cyc, {e.tag, " R3 timing"}, cyc, e.cyc);
            end
        end
    end

    task automatic idle_cycle(input bit junk);
        row_valid = 1'b0;
        row_last  = junk ? 1'($urandom % 2) : 1'b0;
        if (junk) begin
            for (int c = 0; c < LANES; c++) begin
                tmpl_row[c*PIX_W +: PIX_W] = 8'($urandom);
                srch_row[c*PIX_W +: PIX_W] = 8'($urandom);
            end
        end
        @(negedge clk);
    endtask

    // mode 0 random pixels, 1 all 255, 2 all zero; gap_pct inserts junk idles.
    task automatic run_place(input int h, input int mode, input int gap_pct, input string tag);
        longint sum = 0;
        exp_t   e;
        for (int r = 0; r < h; r++) begin
            while (int'($urandom % 100) < gap_pct) idle_cycle(1'b1);
            for (int c = 0; c < LANES; c++) begin
                logic [7:0] a, b;
                a = (mode == 1) ? 8'hFF : (mode == 2) ? 8'h00 : 8'($urandom);
                b = (mode == 1) ? 8'hFF : (mode == 2) ? 8'h00 : 8'($urandom);
                tmpl_row[c*PIX_W +: PIX_W] = a;
                srch_row[c*PIX_W +: PIX_W] = b;
                sum += longint'(a) * longint'(b);
            end
            row_valid = 1'b1;
            row_last  = (r == h - 1);
            if (r == h - 1) begin
                e.val = sum;
                e.cyc = cyc + 1 + LAT;
                e.tag = tag;
                sbq.push_back(e);
            end
            @(negedge clk);
        end
        row_valid = 1'b0;
        row_last  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(res_valid == 1'b0, "R1 valid low in reset", res_valid, 0);
            @(negedge clk);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check(res_valid == 1'b0, "R1 valid low after reset", res_valid, 0);
            idle_cycle(1'b0);
        end

        // R7: tallest placement with largest pixels, then R5 zeros straight after.
        run_place(512, 1, 0, "R7 max");
        run_place(3, 2, 0, "R5 zero after max");
        repeat (3) idle_cycle(1'b0);

        // R6: single-row placements, back to back and separated.
        for (int i = 0; i < 5; i++) run_place(1, 0, 0, "R6 one row");
        idle_cycle(1'b0);
        run_place(1, 1, 0, "R6 one row max");

        // R8: consecutive placements with no idle cycle between them.
        for (int i = 0; i < 6; i++) run_place(2 + int'($urandom % 7), 0, 0, "R8 back to back");

        // R4 and R9: idle cycles with junk pixels and a raised last flag.
        for (int i = 0; i < 8; i++) run_place(1 + int'($urandom % 12), 0, 40, "R4 R9 gaps");

        // R2: random heights and light gaps, then a full-height random placement.
        for (int i = 0; i < 20; i++) run_place(1 + int'($urandom % 64), 0, 10, "R2 random");
        run_place(512, 0, 0, "R2 tall random");

        repeat (LAT + 10) idle_cycle(1'b1);
        check(sbq.size() == 0, "R3 missing results", sbq.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule